// File: doc/BRIEF.md
# Wear-Leveling Logical-to-Physical Unit Map

This block keeps the translation from logical unit numbers to physical erase units for one bank of a flash store. Every physical unit that is not currently holding a logical unit sits in a spare pool. Each physical unit also has a write counter. Whenever a logical unit's contents change, the unit is not updated in place. Instead the table takes a fresh unit from the spare pool and moves the logical number onto it. The unit the logical number used before is then erased and put back into the pool.

To choose the replacement, a scanner walks all physical units one per cycle. It keeps the spare unit with the smallest write counter, and on a tie the lower index wins. While a rewrite is being served the request port reports not ready. A separate lookup port reads the map with a one-cycle latency, and it stays usable during a scan. When a rewrite displaces a unit, an erase command for that unit appears on the output in the same cycle as the rewrite response.

Top module: `wl_xlat_table`

## Requirements
- R1: After reset, no logical number is mapped, every physical unit is spare, every write counter is zero and `req_ready` is high.
- R2: One cycle after `lk_valid` is sampled high, `lk_mapped` and `lk_phys` give the mapping of `lk_lun`. For an unmapped number, `lk_mapped` is 0 and `lk_phys` is 0.
- R3: A successful rewrite allocates the spare unit with the lowest write counter. When several spare units share that counter, the one with the lowest physical index is chosen.
- R4: After a successful rewrite, `resp_err` is 0, `resp_phys` names the new unit and `req_lun` maps to it. That unit's write counter goes up by one and saturates at its maximum value.
- R5: When the rewritten logical number was already mapped, `erase_valid` pulses in the response cycle with `erase_unit` equal to the old unit, and that unit rejoins the spare pool.
- R6: A rewrite of a logical number that was not mapped issues no erase.
- R7: A rewrite when no spare unit exists gives `resp_err`=1 with no erase, and the map and the pool stay unchanged.
- R8: A rewrite changes the mapping of no logical number other than the one requested.
- R9: `req_ready` is low from acceptance until the response. Requests presented while it is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_lun | input | LUN_W | Logical number to look up |
| lk_mapped | output | 1 | Looked-up number is mapped |
| lk_phys | output | PHYS_W | Physical unit of the looked-up number |
| req_valid | input | 1 | Rewrite request |
| req_lun | input | LUN_W | Logical number being rewritten |
| req_ready | output | 1 | Table idle, request accepted |
| resp_valid | output | 1 | One-cycle rewrite response |
| resp_err | output | 1 | No spare unit was available |
| resp_phys | output | PHYS_W | Newly allocated unit |
| erase_valid | output | 1 | Erase command strobe |
| erase_unit | output | PHYS_W | Unit to erase |

## Verification
Directed rewrites on a fresh table show that a tie among equal zero counters goes to the lowest index, and that a second rewrite of the same number erases the first unit. A long random mix of rewrites over a small set of logical numbers drives the counters into saturation and keeps returning units to the pool. Comparing each choice with a model tells the minimum-counter rule apart from a first-free or round-robin pick. A final directed pass fills the pool completely, so that both a new number and an already mapped number run into the empty-pool error, and it checks that the map did not move.

// File: rtl/wl_pkg.sv
package wl_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;
endpackage

// File: rtl/wl_sat_inc.sv
module wl_sat_inc #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        val_o = (val_i == TOP) ? val_i : val_i + W'(1);
    end
endmodule

// File: rtl/wl_spare_scan.sv
module wl_spare_scan #(
    parameter int NUM_PHYS = 1024,
    parameter int CNT_W    = 8,
    localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cand_spare_i,
    input  logic [CNT_W-1:0]  cand_cnt_i,
    output logic [PHYS_W-1:0] idx_o,
    output logic              done_o,
    output logic              found_o,
    output logic [PHYS_W-1:0] best_o
);
    localparam logic [PHYS_W-1:0] LAST = PHYS_W'(NUM_PHYS - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              found;
        logic [PHYS_W-1:0] idx;
        logic [PHYS_W-1:0] best;
        logic [CNT_W-1:0]  best_cnt;
    } scan_t;

    scan_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start_i) begin
            s_d.busy  = 1'b1;
            s_d.idx   = '0;
            s_d.found = 1'b0;
        end else if (s_q.busy) begin
            if (cand_spare_i && (!s_q.found || cand_cnt_i < s_q.best_cnt)) begin
                s_d.found    = 1'b1;
                s_d.best     = s_q.idx;
                s_d.best_cnt = cand_cnt_i;
            end
            if (s_q.idx == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + PHYS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign idx_o   = s_q.idx;
    assign done_o  = s_q.done;
    assign found_o = s_q.found;
    assign best_o  = s_q.best;

    // A new scan never starts over one that is still running.
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> !start_i);

    // The completion strobe lasts one cycle and leaves the scanner idle.
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !s_q.busy && !s_d.done);
endmodule

// File: rtl/wl_xlat_table.sv
module wl_xlat_table #(
    parameter int LUN_W    = 10,
    parameter int NUM_PHYS = 1024,
    parameter int CNT_W    = 8,
    localparam int NUM_LUN = 1 << LUN_W,
    localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [LUN_W-1:0]  lk_lun,
    output logic              lk_mapped,
    output logic [PHYS_W-1:0] lk_phys,
    input  logic              req_valid,
    input  logic [LUN_W-1:0]  req_lun,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [PHYS_W-1:0] resp_phys,
    output logic              erase_valid,
    output logic [PHYS_W-1:0] erase_unit
);
    import wl_pkg::*;

    typedef struct {
        phase_e              phase;
        logic [LUN_W-1:0]    lun;
        logic [NUM_LUN-1:0]  mvalid;
        logic [PHYS_W-1:0]   map [NUM_LUN];
        logic [NUM_PHYS-1:0] spare;
        logic [CNT_W-1:0]    cnt [NUM_PHYS];
        logic                rsp_valid;
        logic                rsp_err;
        logic [PHYS_W-1:0]   rsp_phys;
        logic                ers_valid;
        logic [PHYS_W-1:0]   ers_unit;
        logic                lk_map;
        logic [PHYS_W-1:0]   lk_ph;
    } tbl_t;

    function automatic tbl_t reset_state();
        tbl_t r;
        r.phase     = PH_IDLE;
        r.lun       = '0;
        r.mvalid    = '0;
        r.spare     = '1;
        r.rsp_valid = 1'b0;
        r.rsp_err   = 1'b0;
        r.rsp_phys  = '0;
        r.ers_valid = 1'b0;
        r.ers_unit  = '0;
        r.lk_map    = 1'b0;
        r.lk_ph     = '0;
        for (int i = 0; i < NUM_LUN; i++)  r.map[i] = '0;
        for (int i = 0; i < NUM_PHYS; i++) r.cnt[i] = '0;
        return r;
    endfunction

    tbl_t s_d, s_q;

    logic              scan_start;
    logic [PHYS_W-1:0] scan_idx;
    logic              scan_done;
    logic              scan_found;
    logic [PHYS_W-1:0] scan_best;
    logic [CNT_W-1:0]  next_cnt;
    logic [PHYS_W-1:0] old_unit;

    wl_spare_scan #(
        .NUM_PHYS (NUM_PHYS),
        .CNT_W    (CNT_W)
    ) i_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (scan_start),
        .cand_spare_i (s_q.spare[scan_idx]),
        .cand_cnt_i   (s_q.cnt[scan_idx]),
        .idx_o        (scan_idx),
        .done_o       (scan_done),
        .found_o      (scan_found),
        .best_o       (scan_best)
    );

    wl_sat_inc #(.W(CNT_W)) i_inc (
        .val_i (s_q.cnt[scan_best]),
        .val_o (next_cnt)
    );

    assign old_unit = s_q.map[s_q.lun];

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        s_d.ers_valid = 1'b0;
        scan_start    = 1'b0;

        if (lk_valid) begin
            s_d.lk_map = s_q.mvalid[lk_lun];
            s_d.lk_ph  = s_q.mvalid[lk_lun] ? s_q.map[lk_lun] : '0;
        end

        if (s_q.phase == PH_IDLE) begin
            if (req_valid) begin
                s_d.phase  = PH_SCAN;
                s_d.lun    = req_lun;
                scan_start = 1'b1;
            end
        end else if (scan_done) begin
            s_d.phase     = PH_IDLE;
            s_d.rsp_valid = 1'b1;
            if (!scan_found) begin
                s_d.rsp_err  = 1'b1;
                s_d.rsp_phys = '0;
            end else begin
                s_d.rsp_err  = 1'b0;
                s_d.rsp_phys = scan_best;
                if (s_q.mvalid[s_q.lun]) begin
                    s_d.ers_valid       = 1'b1;
                    s_d.ers_unit        = old_unit;
                    s_d.spare[old_unit] = 1'b1;
                end
                s_d.map[s_q.lun]     = scan_best;
                s_d.mvalid[s_q.lun]  = 1'b1;
                s_d.spare[scan_best] = 1'b0;
                s_d.cnt[scan_best]   = next_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    assign req_ready   = (s_q.phase == PH_IDLE);
    assign resp_valid  = s_q.rsp_valid;
    assign resp_err    = s_q.rsp_err;
    assign resp_phys   = s_q.rsp_phys;
    assign erase_valid = s_q.ers_valid;
    assign erase_unit  = s_q.ers_unit;
    assign lk_mapped   = s_q.lk_map;
    assign lk_phys     = s_q.lk_ph;

    assert_err_pool_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_err |-> s_q.spare == '0);

    assert_erase_on_success_R7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_valid |-> resp_valid && !resp_err);

    assert_new_unit_mapped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_err |->
            !s_q.spare[resp_phys] && s_q.mvalid[s_q.lun] && s_q.map[s_q.lun] == resp_phys);

    assert_erased_rejoins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_valid |-> s_q.spare[erase_unit] && erase_unit != resp_phys);

    assert_ready_after_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);
endmodule

// File: tb/test_wl_xlat_table.sv
module test_wl_xlat_table;
    localparam int LW = 10;
    localparam int NP = 16;
    localparam int PW = 4;
    localparam int CW = 3;
    localparam int NL = 1 << LW;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [LW-1:0] lk_lun = '0;
    logic          lk_mapped;
    logic [PW-1:0] lk_phys;
    logic          req_valid = 1'b0;
    logic [LW-1:0] req_lun = '0;
    logic          req_ready;
    logic          resp_valid;
    logic          resp_err;
    logic [PW-1:0] resp_phys;
    logic          erase_valid;
    logic [PW-1:0] erase_unit;

    int  tests = 0;
    int  fails = 0;
    bit  finished = 0;

    int  m_map [NL];
    bit  m_val [NL];
    bit  m_spare [NP];
    int  m_cnt [NP];

    always #4 clk = ~clk;

    wl_xlat_table #(.LUN_W(LW), .NUM_PHYS(NP), .CNT_W(CW)) i_wl_xlat_table (
        .clk, .rst_n, .lk_valid, .lk_lun, .lk_mapped, .lk_phys,
        .req_valid, .req_lun, .req_ready, .resp_valid, .resp_err, .resp_phys,
        .erase_valid, .erase_unit
    );

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pick_spare();
        int best = -1;
        for (int i = 0; i < NP; i++)
            if (m_spare[i] && (best < 0 || m_cnt[i] < m_cnt[best])) best = i;
        return best;
    endfunction

    task automatic lookup(int lun, string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_lun   = LW'(lun);
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, $sformatf("lookup %0d mapped", lun), int'(lk_mapped), int'(m_val[lun]));
        check(req, $sformatf("lookup %0d phys", lun), int'(lk_phys), m_val[lun] ? m_map[lun] : 0);
    endtask

    task automatic rewrite(int lun, bit poke);
        int exp;
        int n = 0;
        @(negedge clk);
        check("R9", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_lun   = LW'(lun);
        @(negedge clk);
        check("R9", "ready while busy", int'(req_ready), 0);
        if (poke) req_lun = LW'(777);
        else      req_valid = 1'b0;
        while (!resp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        if (!resp_valid) begin
            check("R4", "response timeout", 0, 1);
            return;
        end
        exp = pick_spare();
        if (exp < 0) begin
            check("R7", "error on empty pool", int'(resp_err), 1);
            check("R7", "no erase on error", int'(erase_valid), 0);
        end else begin
            check("R4", "no error", int'(resp_err), 0);
            check("R3", "allocated unit", int'(resp_phys), exp);
            if (m_val[lun]) begin
                check("R5", "erase strobe", int'(erase_valid), 1);
                check("R5", "erased unit", int'(erase_unit), m_map[lun]);
                m_spare[m_map[lun]] = 1'b1;
            end else begin
                check("R6", "no erase for first write", int'(erase_valid), 0);
            end
            m_spare[exp] = 1'b0;
            if (m_cnt[exp] < CMAX) m_cnt[exp]++;
            m_map[lun] = exp;
            m_val[lun] = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NL; i++) begin m_val[i] = 1'b0; m_map[i] = 0; end
        for (int i = 0; i < NP; i++) begin m_spare[i] = 1'b1; m_cnt[i] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1", "ready after reset", int'(req_ready), 1);
        check("R1", "no response after reset", int'(resp_valid), 0);
        check("R1", "no erase after reset", int'(erase_valid), 0);
        lookup(0, "R1");
        lookup(1023, "R2");

        // R3 tie among zero counters, then R5 erase of the first unit
        rewrite(3, 1'b0);
        rewrite(3, 1'b0);
        lookup(3, "R4");
        // R9 request held high while busy is ignored
        rewrite(7, 1'b1);
        lookup(777, "R9");
        lookup(3, "R8");

        for (int i = 0; i < 10; i++) rewrite(i, 1'b0);

        for (int k = 0; k < 250; k++) begin
            int l = $urandom_range(0, 9);
            rewrite(l, 1'b0);
            lookup(l, "R4");
            lookup($urandom_range(0, 9), "R8");
        end

        // fill the pool, then both a new and a mapped number must fail (R7)
        for (int i = 500; i < 506; i++) rewrite(i, 1'b0);
        rewrite(600, 1'b0);
        rewrite(3, 1'b0);
        lookup(3, "R7");
        lookup(600, "R7");
        lookup(505, "R7");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule